// File: doc/BRIEF.md
# Power-of-Two Twiddle Butterfly for Modular Transforms

This unit performs one radix-2 butterfly of a number-theoretic transform over the residues modulo the prime p = 2^32 + 1. It also covers the inverse transform. Each cycle it accepts two residues, called upper and lower, and two twiddle exponents. A 2-bit mode selects how the upper operand is treated. The lower operand is always multiplied by 2^e_down. The upper operand is multiplied by 2^e_up only in the last stage of the inverse transform. That multiplication folds the 1/k normalisation into the butterfly, so no separate scaling pass is needed. The unit then outputs the modular sum and the modular difference of the two operands.

For this modulus the root of unity is 2, and 2^32 ≡ −1. Every twiddle is therefore a power of two, and an inverse twiddle is simply a different exponent. For example, 1/64 ≡ 2^58. Each twiddle product is built from a shift, a fold of the wide product into 33 bits, and a conditional negation. No multiplier is used.

The unit has two pipeline stages and accepts a new butterfly on every cycle. Valid and mode travel with the data. A sequencer outside this block chooses the exponents and addresses for a complete transform.

Top module: `bfly_unit`

## Requirements
- R1: While rst_ni is low, valid_o is 0. The first output cycle after reset is also 0 unless valid_i was high two cycles earlier.
- R2: valid_o and mode_o repeat valid_i and mode_i with a latency of exactly 2 cycles. Butterflies presented on consecutive cycles come out on consecutive cycles.
- R3: The lower operand is v = x_down_i · 2^exp_down_i mod p in every mode.
- R4: Modes are encoded as 0 = forward, 1 = inverse, 2 = inverse final stage and 3 = reserved. In every mode except 2 the upper operand is u = x_up_i unchanged, and exp_up_i has no effect.
- R5: In mode 2 the upper operand is u = x_up_i · 2^exp_up_i mod p.
- R6: x_up_o = (u + v) mod p. A sum equal to p gives 0.
- R7: x_down_o = (u − v) mod p. A negative difference is corrected by adding p.
- R8: Both outputs are below p whenever both data inputs are below p. The residue p − 1 = 2^32 is accepted and produced.
- R9: An exponent of 32 or more is handled through 2^32 ≡ −1. For example, 2^32 · x gives p − x, and an exponent of 63 gives −2^31 · x mod p.
- R10: Asserting rst_ni while a butterfly is in flight clears valid_o immediately, and that butterfly is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input butterfly present |
| mode_i | input | 2 | 0 forward, 1 inverse, 2 inverse final stage, 3 reserved |
| x_up_i | input | 33 | Upper residue |
| x_down_i | input | 33 | Lower residue |
| exp_up_i | input | 6 | Upper twiddle exponent (used in mode 2 only) |
| exp_down_i | input | 6 | Lower twiddle exponent |
| valid_o | output | 1 | Output butterfly present |
| mode_o | output | 2 | Mode of the output butterfly |
| x_up_o | output | 33 | (u + v) mod p |
| x_down_o | output | 33 | (u − v) mod p |

## Verification
The bench builds the unit with its default width M = 33, which fixes p = 2^32 + 1 and 6-bit exponents. At this width the full exponent range 0..63 can be exercised, including both sides of the negation threshold at 32. It also reaches the 33-bit residue 2^32, and sums that land exactly on p. A streamed pseudo-random sweep is compared against a reference model that multiplies by 2 one step at a time, using 128-bit modular arithmetic. Because that model never uses the fold identity, the fold and negation logic is checked rather than mirrored.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  typedef enum logic [1:0] {
    MODE_FWD      = 2'd0,
    MODE_INV      = 2'd1,
    MODE_INV_LAST = 2'd2,
    MODE_RSVD     = 2'd3
  } bfly_mode_e;
endpackage

// File: rtl/bfly_pow2_mul.sv
// x * 2^e mod (2^(M-1)+1): fold e into [0,M-1) with a sign, shift, special reduce.
module bfly_pow2_mul #(
  parameter int unsigned M  = 33,
  parameter int unsigned EW = $clog2(2*(M-1))
) (
  input  logic [M-1:0]  x_i,
  input  logic [EW-1:0] e_i,
  output logic [M-1:0]  y_o
);
  localparam int unsigned H = M - 1;
  localparam logic [M-1:0] P = {1'b1, {(M-2){1'b0}}, 1'b1};

  logic                neg;
  logic [EW-1:0]       shamt;
  logic [2*M-1:0]      prod;
  logic [M-2:0]        lo, mid;
  logic [1:0]          hi;
  logic signed [M+1:0] y1, y1_fix;
  logic [M-1:0]        r;

  always_comb begin
    neg    = (e_i >= EW'(H));
    shamt  = neg ? (e_i - EW'(H)) : e_i;
    prod   = {{M{1'b0}}, x_i} << shamt;
    lo     = prod[M-2:0];
    mid    = prod[2*M-3:M-1];
    hi     = prod[2*M-1:2*M-2];
    y1     = $signed({3'b000, lo}) + $signed({{M{1'b0}}, hi}) - $signed({3'b000, mid});
    y1_fix = (y1 < 0) ? (y1 + $signed({2'b00, P})) : y1;
    r      = y1_fix[M-1:0];
    y_o    = (neg && (r != '0)) ? (P - r) : r;
  end
endmodule

// File: rtl/bfly_modaddsub.sv
module bfly_modaddsub #(
  parameter int unsigned M = 33
) (
  input  logic [M-1:0] u_i,
  input  logic [M-1:0] v_i,
  output logic [M-1:0] sum_o,
  output logic [M-1:0] dif_o
);
  localparam logic [M:0] PW = {2'b01, {(M-2){1'b0}}, 1'b1};

  logic [M:0] s, d;

  always_comb begin
    s     = {1'b0, u_i} + {1'b0, v_i};
    d     = {1'b0, u_i} - {1'b0, v_i};
    sum_o = (s >= PW) ? M'(s - PW) : s[M-1:0];
    dif_o = d[M] ? M'(d + PW) : d[M-1:0];
  end
endmodule

// File: rtl/bfly_unit.sv
module bfly_unit
  import bfly_pkg::*;
#(
  parameter int unsigned M = 33
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [1:0]                    mode_i,
  input  logic [M-1:0]                  x_up_i,
  input  logic [M-1:0]                  x_down_i,
  input  logic [$clog2(2*(M-1))-1:0]    exp_up_i,
  input  logic [$clog2(2*(M-1))-1:0]    exp_down_i,
  output logic                          valid_o,
  output logic [1:0]                    mode_o,
  output logic [M-1:0]                  x_up_o,
  output logic [M-1:0]                  x_down_o
);
  localparam int unsigned EW = $clog2(2*(M-1));
  localparam int unsigned NB = 2;  // 0: upper branch, 1: lower branch

  logic [M-1:0]  tw_x [NB];
  logic [EW-1:0] tw_e [NB];
  logic [M-1:0]  tw_y [NB];

  assign tw_x[0] = x_up_i;
  assign tw_e[0] = exp_up_i;
  assign tw_x[1] = x_down_i;
  assign tw_e[1] = exp_down_i;

  for (genvar g = 0; g < NB; g++) begin : g_tw
    bfly_pow2_mul #(.M(M), .EW(EW)) i_mul (
      .x_i (tw_x[g]),
      .e_i (tw_e[g]),
      .y_o (tw_y[g])
    );
  end

  logic [M-1:0] u_d;
  assign u_d = (mode_i == MODE_INV_LAST) ? tw_y[0] : x_up_i;

  // stage 1: twiddled operands
  logic         s1_vld;
  logic [1:0]   s1_mode;
  logic [M-1:0] s1_u, s1_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_mode <= '0;
      s1_u    <= '0;
      s1_v    <= '0;
    end else begin
      s1_vld  <= valid_i;
      s1_mode <= mode_i;
      s1_u    <= u_d;
      s1_v    <= tw_y[1];
    end
  end

  logic [M-1:0] sum_d, dif_d;

  bfly_modaddsub #(.M(M)) i_addsub (
    .u_i   (s1_u),
    .v_i   (s1_v),
    .sum_o (sum_d),
    .dif_o (dif_d)
  );

  // stage 2: outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      mode_o   <= '0;
      x_up_o   <= '0;
      x_down_o <= '0;
    end else begin
      valid_o  <= s1_vld;
      mode_o   <= s1_mode;
      x_up_o   <= sum_d;
      x_down_o <= dif_d;
    end
  end
endmodule

// File: rtl/bfly_unit_chk.sv
module bfly_unit_chk #(
  parameter int unsigned M = 33
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic [1:0]                 mode_i,
  input logic [M-1:0]               x_up_i,
  input logic [M-1:0]               x_down_i,
  input logic [$clog2(2*(M-1))-1:0] exp_up_i,
  input logic [$clog2(2*(M-1))-1:0] exp_down_i,
  input logic                       valid_o,
  input logic [1:0]                 mode_o,
  input logic [M-1:0]               x_up_o,
  input logic [M-1:0]               x_down_o
);
  localparam logic [M+1:0] PX = {3'b001, {(M-2){1'b0}}, 1'b1};

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> !valid_o);

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_mode_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && valid_o) |-> (mode_o == $past(mode_i, 2)));

  p_out_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({2'b00, x_up_o} < PX && {2'b00, x_down_o} < PX));

  // sum of outputs is 2u; u is the raw upper input outside mode 2
  p_upper_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && valid_o && mode_o != 2'd2 && {2'b00, $past(x_up_i, 2)} < PX)
    |-> ((({2'b00, x_up_o} + {2'b00, x_down_o}) % PX) ==
         ({1'b0, $past(x_up_i, 2), 1'b0} % PX)));
endmodule

bind bfly_unit bfly_unit_chk #(.M(M)) i_bfly_unit_chk (.*);

// File: tb/test_bfly_unit.sv
module test_bfly_unit;
  localparam int M  = 33;
  localparam int EW = 6;
  localparam logic [127:0] P = 128'h1_0000_0001;
  localparam int NT = 12;
  localparam int NR = 160;
  localparam int N  = NT + NR;

  typedef struct packed {
    logic [1:0]   md;
    logic [M-1:0] xu, xd;
    logic [EW-1:0] eu, ed;
    logic [M-1:0] up, dn;
  } vec_t;

  // mode, x_up, x_down, e_up, e_down, expected up, expected down
  localparam vec_t TBL [NT] = '{
    '{2'd0, 33'd5,          33'd3,          6'd0,  6'd0,  33'd8,          33'd2},           // R3 R6 R7
    '{2'd0, 33'd1,          33'd1,          6'd9,  6'd4,  33'd17,         33'd4294967282},  // R3 R7
    '{2'd0, 33'd4294967296, 33'd4294967296, 6'd0,  6'd0,  33'd4294967295, 33'd0},           // R8
    '{2'd0, 33'd0,          33'd1,          6'd0,  6'd32, 33'd4294967296, 33'd1},           // R9
    '{2'd0, 33'd10,         33'd3,          6'd0,  6'd63, 33'd2147483660, 33'd2147483657},  // R9
    '{2'd1, 33'd7,          33'd4294967296, 6'd5,  6'd1,  33'd5,          33'd9},           // R4
    '{2'd2, 33'd3,          33'd0,          6'd58, 6'd0,  33'd4093640705, 33'd4093640705},  // R5
    '{2'd2, 33'd1,          33'd1,          6'd0,  6'd0,  33'd2,          33'd0},           // R5
    '{2'd2, 33'd4294967296, 33'd5,          6'd32, 6'd2,  33'd21,         33'd4294967278},  // R5 R9
    '{2'd3, 33'd9,          33'd2,          6'd1,  6'd1,  33'd13,         33'd5},           // R4
    '{2'd0, 33'd4294967296, 33'd1,          6'd0,  6'd0,  33'd0,          33'd4294967295},  // R6
    '{2'd1, 33'd0,          33'd0,          6'd17, 6'd40, 33'd0,          33'd0}            // R6 R7
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [M-1:0]  x_up_i = '0, x_down_i = '0;
  logic [EW-1:0] exp_up_i = '0, exp_down_i = '0;
  logic          valid_o;
  logic [1:0]    mode_o;
  logic [M-1:0]  x_up_o, x_down_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  vec_t vecs [N];

  always #4 clk_i = ~clk_i;

  bfly_unit #(.M(M)) i_bfly_unit (.*);

  function automatic logic [127:0] mulp(logic [127:0] x, int e);
    logic [127:0] a = x % P;
    for (int i = 0; i < e; i++) a = (a << 1) % P;
    return a;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic vld);
    valid_i    = vld;
    mode_i     = v.md;
    x_up_i     = v.xu;
    x_down_i   = v.xd;
    exp_up_i   = v.eu;
    exp_down_i = v.ed;
  endtask

  initial begin
    logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < NT; i++) vecs[i] = TBL[i];
    for (int i = NT; i < N; i++) begin
      vec_t v;
      logic [127:0] u, w;
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      v.md = s[1:0];
      v.eu = s[7:2];
      v.ed = s[13:8];
      v.xu = M'({95'd0, s[46:14]} % P);
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      v.xd = M'({95'd0, s[40:8]} % P);
      u = (v.md == 2'd2) ? mulp({95'd0, v.xu}, int'(v.eu)) : {95'd0, v.xu};
      w = mulp({95'd0, v.xd}, int'(v.ed));
      v.up = M'((u + w) % P);
      v.dn = M'((u + P - w) % P);
      vecs[i] = v;
    end

    // R1: idle in reset even with valid_i high
    drive(TBL[0], 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R1 valid_o in reset", {127'd0, valid_o}, 128'd0);
    drive(TBL[0], 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid_o after reset", {127'd0, valid_o}, 128'd0);

    // stream: table then sweep, one per cycle
    for (int t = 0; t < N + 2; t++) begin
      @(negedge clk_i);
      if (t >= 2) begin
        chk("R2 valid_o", {127'd0, valid_o}, 128'd1);
        chk("R2 mode_o", {126'd0, mode_o}, {126'd0, vecs[t-2].md});
        chk("R6 x_up_o", {95'd0, x_up_o}, {95'd0, vecs[t-2].up});
        chk("R7 x_down_o", {95'd0, x_down_o}, {95'd0, vecs[t-2].dn});
        if ({95'd0, x_up_o} >= P || {95'd0, x_down_o} >= P) chk("R8 range", 128'd1, 128'd0);
      end
      if (t < N) drive(vecs[t], 1'b1);
      else drive(TBL[0], 1'b0);
    end
    @(negedge clk_i);
    chk("R2 valid_o drains", {127'd0, valid_o}, 128'd0);

    // R4: exp_up_i is ignored in mode 1, swept over its range
    for (int e = 0; e < 64; e += 21) begin
      vec_t v = TBL[5];
      v.eu = EW'(e);
      drive(v, 1'b1);
      @(negedge clk_i); drive(v, 1'b0);
      @(negedge clk_i);
      chk("R4 x_up_o exp_up ignored", {95'd0, x_up_o}, 128'd5);
      chk("R4 x_down_o exp_up ignored", {95'd0, x_down_o}, 128'd9);
    end

    // R10: reset while a butterfly is in flight
    drive(TBL[1], 1'b1);
    @(negedge clk_i); drive(TBL[1], 1'b0);
    #1 rst_ni = 1'b0;
    #1 chk("R10 valid_o cleared", {127'd0, valid_o}, 128'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 in-flight dropped", {127'd0, valid_o}, 128'd0);
    @(negedge clk_i);
    chk("R10 stays idle", {127'd0, valid_o}, 128'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule